// File: doc/BRIEF.md
# Five-Level Flying-Capacitor Switch-State Selector

This block produces the six gate commands for a two-pole, five-level, flying-capacitor dual-buck inverter stage. Each pole has three switches: upper, middle and lower. The block takes four inputs from the modulator:
- the sign of the inductor current;
- a two-bit code for the reference region;
- a carrier-comparison PWM bit;
- a digitized voltage for each pole's first flying capacitor.

From these it chooses a three-bit switch code for the pole that is carrying current. The other pole is held fully off. Because the two poles never conduct together, no dead time is needed between gate transitions. Any code may follow any other.

Most output levels can be produced by more than one switch code. The block uses this redundancy to hold a pole's first flying capacitor near a programmable midpoint, while the second capacitor stays net-balanced. A hysteresis flag per pole picks either the charging group or the discharging group of codes. The flag moves to the discharging group when the capacitor voltage rises above midpoint plus band. It moves back to the charging group when the voltage falls below midpoint minus band. Inside the band it keeps its last value. The threshold arithmetic has one bit of headroom, so a sum above full scale or a band wider than the midpoint never wraps.

Top module: `fcGateSelect`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) drives all six gate outputs to 0 at that edge. Both hysteresis flags restart in the charging group.
- R2: The target level index is `region + pwmHigh`, from 0 (lowest, -Ud/2) to 4 (highest, +Ud/2). Region 0 spans levels 0/1, region 1 spans levels 1/2, region 2 spans levels 2/3 and region 3 spans levels 3/4. A gate code is written {upper, middle, lower}.
- R3: In the charging group, levels 0 to 4 use codes 000, 001, 100, 110 and 111.
- R4: In the discharging group, levels 0 to 4 use codes 000, 010, 011, 101 and 111.
- R5: A pole's flag enters the discharging group on the clock edge after its capacitor word is strictly greater than `ubLevel + hystBand`.
- R6: A pole's flag enters the charging group on the clock edge after its capacitor word is strictly less than `ubLevel - hystBand`. At values equal to either bound, or between them, the flag keeps its previous value.
- R7: With `curNeg` = 0, pole 1 drives the selected code using pole 1's flag, and all pole 2 gates are 0.
- R8: With `curNeg` = 1, pole 2 drives the selected code using pole 2's flag, and all pole 1 gates are 0.
- R9: Gate outputs are registered. A change on `region`, `pwmHigh` or `curNeg` appears at the outputs on the first clock edge after it. A change in a capacitor word reaches the outputs one edge later than that, because it first passes through the flag.
- R10: The bound computation does not overflow. If `ubLevel + hystBand` exceeds 4095, the flag never enters the discharging group. If `hystBand > ubLevel`, the flag never enters the charging group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| curNeg | input | 1 | 1 when inductor current is negative (pole 2 active) |
| region | input | 2 | Reference region code, 0 = lowest |
| pwmHigh | input | 1 | Carrier comparison: 1 selects the upper level of the region |
| vCap1 | input | 12 | Pole 1 first flying-capacitor voltage, unsigned |
| vCap2 | input | 12 | Pole 2 first flying-capacitor voltage, unsigned |
| ubLevel | input | 12 | Capacitor balance midpoint, unsigned |
| hystBand | input | 12 | Hysteresis half-width, unsigned |
| pole1Gates | output | 3 | Pole 1 gates {upper, middle, lower} |
| pole2Gates | output | 3 | Pole 2 gates {upper, middle, lower} |

## Verification
A hysteresis flag that is wrong shows up only at levels 1, 2 and 3, where the two code groups differ, and only on the pole currently carrying current. It appears one edge after the capacitor word crosses a bound plus one more edge through the gate register. Each flag test therefore reads a middle level on the active pole exactly two edges after the voltage moves. A wrong pole selection or level decode appears on the first edge after the input change: either both poles drive nonzero codes, or the active pole's code does not match the table. Flag independence is tested by holding the two poles' flags in opposite groups and then switching current polarity.

// File: rtl/fcGatePkg.sv
package fcGatePkg;
  localparam int VW      = 12;
  localparam int CODE_W  = 3;
  localparam int NPOLES  = 2;
  localparam int NLEVELS = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic poleTwo;       // pole 2 is the switching pole
    logic dischargeSel;  // active pole uses the discharging code group
  } selStrobe_t;
endpackage

// File: rtl/fcGateCtrl.sv
module fcGateCtrl
  import fcGatePkg::*;
#(
  parameter int W = VW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     curNeg,
  input  logic [NPOLES-1:0][W-1:0] vCap,
  input  logic [W-1:0]             ubLevel,
  input  logic [W-1:0]             hystBand,
  output selStrobe_t               strobe
);
  localparam int SW = W + 1;

  logic [SW-1:0]     upperBound;
  logic [SW-1:0]     lowerBound;
  logic              lowerValid;
  logic [NPOLES-1:0] dischargeFlag;

  // one bit of headroom: sum never wraps, lower bound guarded when band > midpoint
  always_comb begin
    upperBound = {1'b0, ubLevel} + {1'b0, hystBand};
    lowerValid = (hystBand <= ubLevel);
    lowerBound = {1'b0, ubLevel} - {1'b0, hystBand};
  end

  for (genvar p = 0; p < NPOLES; p++) begin : gPole
    logic aboveHi;
    logic belowLo;

    assign aboveHi = ({1'b0, vCap[p]} > upperBound);
    assign belowLo = lowerValid && ({1'b0, vCap[p]} < lowerBound);

    always_ff @(posedge clk) begin
      if (rst)          dischargeFlag[p] <= 1'b0;
      else if (aboveHi) dischargeFlag[p] <= 1'b1;
      else if (belowLo) dischargeFlag[p] <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, vCap[p]} > ({1'b0, ubLevel} + {1'b0, hystBand})) |=> dischargeFlag[p]); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      ((hystBand <= ubLevel) && ({1'b0, vCap[p]} + {1'b0, hystBand} < {1'b0, ubLevel}))
        |=> !dischargeFlag[p]); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!aboveHi && !belowLo) |=> $stable(dischargeFlag[p])); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (upperBound[W] && !dischargeFlag[p]) |=> !dischargeFlag[p]); // R10
  end

  always_comb begin
    strobe.poleTwo      = curNeg;
    strobe.dischargeSel = curNeg ? dischargeFlag[1] : dischargeFlag[0];
  end
endmodule

// File: rtl/fcGateDatapath.sv
module fcGateDatapath
  import fcGatePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        region,
  input  logic              pwmHigh,
  input  selStrobe_t        strobe,
  output logic [CODE_W-1:0] pole1Gates,
  output logic [CODE_W-1:0] pole2Gates
);
  localparam int LW = $clog2(NLEVELS);

  logic [LW-1:0]                  levelIdx;
  logic [CODE_W-1:0]              levelCode;
  logic [NPOLES-1:0][CODE_W-1:0]  gatesQ;

  assign levelIdx = LW'(region) + LW'(pwmHigh);

  // redundant code choice: both groups share the extreme levels
  always_comb begin
    unique case (levelIdx)
      3'd0:    levelCode = 3'b000;
      3'd1:    levelCode = strobe.dischargeSel ? 3'b010 : 3'b001;
      3'd2:    levelCode = strobe.dischargeSel ? 3'b011 : 3'b100;
      3'd3:    levelCode = strobe.dischargeSel ? 3'b101 : 3'b110;
      default: levelCode = 3'b111;
    endcase
  end

  for (genvar p = 0; p < NPOLES; p++) begin : gGate
    logic isActive;
    assign isActive = (strobe.poleTwo == (p == 1));
    always_ff @(posedge clk) begin
      if (rst)           gatesQ[p] <= '0;
      else if (isActive) gatesQ[p] <= levelCode;
      else               gatesQ[p] <= '0;
    end
  end

  assign pole1Gates = gatesQ[0];
  assign pole2Gates = gatesQ[1];

  AST_IDLE_POLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !((|pole1Gates) && (|pole2Gates))); // R7, R8
  AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (region == 2'd3 && pwmHigh && !strobe.poleTwo) |=> (pole1Gates == 3'b111)); // R2
  AST_BOTTOM_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (region == 2'd0 && !pwmHigh) |=> (pole1Gates == 3'b000 && pole2Gates == 3'b000)); // R2
endmodule

// File: rtl/fcGateSelect.sv
module fcGateSelect
  import fcGatePkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          curNeg,
  input  logic [1:0]    region,
  input  logic          pwmHigh,
  input  logic [VW-1:0] vCap1,
  input  logic [VW-1:0] vCap2,
  input  logic [VW-1:0] ubLevel,
  input  logic [VW-1:0] hystBand,
  output logic [2:0]    pole1Gates,
  output logic [2:0]    pole2Gates
);
  selStrobe_t                 strobe;
  logic [NPOLES-1:0][VW-1:0]  vCapBus;

  assign vCapBus = {vCap2, vCap1};

  fcGateCtrl #(.W(VW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .curNeg   (curNeg),
    .vCap     (vCapBus),
    .ubLevel  (ubLevel),
    .hystBand (hystBand),
    .strobe   (strobe)
  );

  fcGateDatapath dp_i (
    .clk        (clk),
    .rst        (rst),
    .region     (region),
    .pwmHigh    (pwmHigh),
    .strobe     (strobe),
    .pole1Gates (pole1Gates),
    .pole2Gates (pole2Gates)
  );
endmodule

// File: tb/fcGateSelect_tb_top.sv
module fcGateSelect_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        curNeg;
  logic [1:0]  region;
  logic        pwmHigh;
  logic [11:0] vCap1, vCap2, ubLevel, hystBand;
  logic [2:0]  pole1Gates, pole2Gates;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  fcGateSelect dut_i (
    .clk(clk), .rst(rst), .curNeg(curNeg), .region(region), .pwmHigh(pwmHigh),
    .vCap1(vCap1), .vCap2(vCap2), .ubLevel(ubLevel), .hystBand(hystBand),
    .pole1Gates(pole1Gates), .pole2Gates(pole2Gates)
  );

  // expected code from the R3/R4 tables
  function automatic logic [2:0] expCode(input int lvl, input bit dis);
    case (lvl)
      0:       return 3'b000;
      1:       return dis ? 3'b010 : 3'b001;
      2:       return dis ? 3'b011 : 3'b100;
      3:       return dis ? 3'b101 : 3'b110;
      default: return 3'b111;
    endcase
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic checkGates(input string req, input logic [2:0] e1, input logic [2:0] e2);
    testCnt++;
    if (pole1Gates !== e1 || pole2Gates !== e2) begin
      failCnt++;
      $display("FAIL %s: gates p1=%b p2=%b expected p1=%b p2=%b", req, pole1Gates, pole2Gates, e1, e2);
    end
  endtask

  task automatic setLevel(input logic [1:0] r, input logic pw);
    region = r; pwmHigh = pw;
  endtask

  // walks all regions and PWM states on one pole; R2 level index = region + pwm
  task automatic sweepPole(input bit neg, input bit dis, input string req);
    curNeg = neg;
    for (int r = 0; r < 4; r++) begin
      for (int pw = 0; pw < 2; pw++) begin
        setLevel(2'(r), 1'(pw));
        step(1);
        if (neg) checkGates(req, 3'b000, expCode(r + pw, dis));
        else     checkGates(req, expCode(r + pw, dis), 3'b000);
      end
    end
  endtask

  task automatic testResetState();
    rst = 1'b1; curNeg = 1'b0; setLevel(2'd3, 1'b1);
    ubLevel = 12'd2048; hystBand = 12'd100; vCap1 = 12'd2048; vCap2 = 12'd2048;
    step(2);
    checkGates("R1 reset", 3'b000, 3'b000);
    rst = 1'b0;
    setLevel(2'd1, 1'b0);
    step(1);
    checkGates("R1 flags start in charge group", expCode(1, 0), 3'b000);
  endtask

  task automatic testChargeSweep();
    sweepPole(1'b0, 1'b0, "R3 R2 R7 charge group pole 1");
  endtask

  task automatic testDischargeEntry();
    curNeg = 1'b0; setLevel(2'd0, 1'b1);
    vCap1 = 12'd2148;  // equal to upper bound: hold
    step(2);
    checkGates("R6 hold at upper bound", expCode(1, 0), 3'b000);
    vCap1 = 12'd2149;  // strictly above
    step(2);
    checkGates("R5 enter discharge", expCode(1, 1), 3'b000);
    sweepPole(1'b0, 1'b1, "R4 discharge group pole 1");
  endtask

  task automatic testHoldBand();
    curNeg = 1'b0; setLevel(2'd1, 1'b1);
    vCap1 = 12'd2048;
    step(2);
    checkGates("R6 hold inside band", expCode(2, 1), 3'b000);
    vCap1 = 12'd1948;  // equal to lower bound
    step(2);
    checkGates("R6 hold at lower bound", expCode(2, 1), 3'b000);
    vCap1 = 12'd1947;
    step(2);
    checkGates("R6 enter charge", expCode(2, 0), 3'b000);
  endtask

  task automatic testNegativePole();
    curNeg = 1'b0; setLevel(2'd0, 1'b1);
    vCap1 = 12'd2300; vCap2 = 12'd2048;
    step(2);
    checkGates("R7 pole 1 discharge flag set", expCode(1, 1), 3'b000);
    sweepPole(1'b1, 1'b0, "R8 pole 2 own flag charge");
    vCap2 = 12'd2300;
    step(2);
    sweepPole(1'b1, 1'b1, "R8 pole 2 own flag discharge");
    vCap2 = 12'd1000;
    step(2);
    curNeg = 1'b0; setLevel(2'd2, 1'b0);
    step(1);
    checkGates("R7 back to pole 1 with its flag", expCode(2, 1), 3'b000);
  endtask

  task automatic testLatency();
    curNeg = 1'b0; vCap1 = 12'd2048; setLevel(2'd2, 1'b0);
    step(1);
    pwmHigh = 1'b1;
    #1;
    checkGates("R9 no change before edge", expCode(2, 1), 3'b000);
    step(1);
    checkGates("R9 change after one edge", expCode(3, 1), 3'b000);
    curNeg = 1'b1;
    step(1);
    checkGates("R9 pole swap after one edge", 3'b000, expCode(3, 0));
  endtask

  task automatic testOverflow();
    curNeg = 1'b0; setLevel(2'd0, 1'b1);
    ubLevel = 12'd4000; hystBand = 12'd200; vCap1 = 12'd100;
    step(2);
    checkGates("R10 charge before overflow test", expCode(1, 0), 3'b000);
    vCap1 = 12'd4095;
    step(2);
    checkGates("R10 full scale cannot pass wide upper bound", expCode(1, 0), 3'b000);
    ubLevel = 12'd100; hystBand = 12'd300; vCap1 = 12'd500;
    step(2);
    checkGates("R10 discharge before underflow test", expCode(1, 1), 3'b000);
    vCap1 = 12'd0;
    step(2);
    checkGates("R10 zero cannot pass negative lower bound", expCode(1, 1), 3'b000);
  endtask

  task automatic testMidReset();
    curNeg = 1'b0; setLevel(2'd2, 1'b1);
    step(1);
    checkGates("R1 active before reset", expCode(3, 1), 3'b000);
    rst = 1'b1;
    step(1);
    checkGates("R1 reset clears gates", 3'b000, 3'b000);
    ubLevel = 12'd2048; hystBand = 12'd100; vCap1 = 12'd2048;
    rst = 1'b0;
    step(1);
    checkGates("R1 flag returns to charge", expCode(3, 0), 3'b000);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    #2_000_000;
    testCnt++; failCnt++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1'b1; curNeg = 1'b0; region = 2'd0; pwmHigh = 1'b0;
    vCap1 = '0; vCap2 = '0; ubLevel = '0; hystBand = '0;
    @(negedge clk);
    testResetState();
    testChargeSweep();
    testDischargeEntry();
    testHoldBand();
    testNegativePole();
    testLatency();
    testOverflow();
    testMidReset();
    report();
  end
endmodule